// File: doc/BRIEF.md
# Dual-Bank USB OUT Endpoint Receiver

This block is the receive half of a single bulk or interrupt OUT endpoint in a USB device. The packet engine upstream signals each OUT token. It then delivers the payload as a byte stream with a CRC verdict on the final byte. The block stores accepted payloads in two banks and uses them in turn. While firmware drains one bank, the host can already fill the other. For every packet that ends cleanly, the block returns a handshake choice of ACK, NAK or STALL.

The firmware side has these controls and views:
- a full flag for each bank, with a clear strobe for each flag;
- a byte count for each bank;
- a combinational read port into either bank;
- a read-order pointer that names the oldest filled bank;
- a force-stall input that models the endpoint halt state;
- an interrupt that stays high while any bank holds data.

The payload input is a valid/ready stream. `rx_ready` rises in the cycle after an OUT token and falls after the beat flagged last. Outside that window, beats are not taken and have no effect. Inside it, the block never applies back-pressure. The upstream engine may hold `rx_valid` low between bytes. Each beat carries one byte, and the beat with `rx_last` set carries the final byte of the payload.

Top module: `ppep_out_endpoint`

## Requirements
- R1: Accepted payloads are written to bank 0, then bank 1, then bank 0 again, and so on. The write pointer is 0 after reset and moves only when a payload is accepted.
- R2: A payload of 1 to 64 bytes is accepted when all of the following hold at its last beat: the CRC is good, stall is not forced, and the target bank was empty at the token. On acceptance, the cycle after the last beat shows the bank's flag set, its byte count, and `hs_valid` with `hs_code` = 2'b01 (ACK). The other codes are NAK = 2'b10 and STALL = 2'b11.
- R3: `irq` is high exactly when at least one bit of `bank_full` is set.
- R4: A `bank_clr` pulse clears that bank's flag, which lets the bank be reused. A packet whose target bank is still full at its token is answered with NAK. Such a packet stores nothing and leaves the write pointer unchanged.
- R5: `rd_bank` is 0 after reset. It toggles when the bank it names is cleared. A clear pulse aimed at an empty bank changes nothing. A clear of the other bank leaves `rd_bank` unchanged.
- R6: When `force_stall` is high at the token, the packet is answered with STALL. Nothing is stored, no flag changes, and no count changes.
- R7: When `rx_crc_ok` is low at the last beat, there is no handshake, no flag is set, and the write pointer does not move.
- R8: A payload longer than 64 bytes gets no handshake and sets no flag.
- R9: `rx_ready` is low after reset. It is high from the cycle after a token until the last beat. Beats offered while it is low have no effect.
- R10: Byte i of a stored payload can be read at `rd_addr` = i of its bank, selected by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_out | input | 1 | OUT token strobe, starts a packet |
| rx_valid | input | 1 | Payload byte valid |
| rx_ready | output | 1 | Packet window open |
| rx_data | input | 8 | Payload byte |
| rx_last | input | 1 | Marks the final byte |
| rx_crc_ok | input | 1 | CRC verdict, sampled with the last byte |
| hs_valid | output | 1 | Handshake choice valid (one cycle) |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| force_stall | input | 1 | Endpoint halt: answer with STALL |
| bank_full | output | 2 | Per-bank received flags |
| bank_clr | input | 2 | Per-bank flag clear strobes |
| bank0_cnt | output | 7 | Byte count held in bank 0 |
| bank1_cnt | output | 7 | Byte count held in bank 1 |
| rd_bank | output | 1 | Oldest filled bank (read order) |
| rd_sel | input | 1 | Bank chosen for reading |
| rd_addr | input | 6 | Byte address within the bank |
| rd_data | output | 8 | Byte at rd_sel/rd_addr |
| irq | output | 1 | Any bank holds data |

## Verification
Two things can land on the same clock edge: the completion of a packet, which sets one bank's flag, and a firmware clear of the other bank, which also moves the read pointer. The bench provokes this by pulsing `bank_clr` for bank 0 in the cycle of the last beat of a packet headed for bank 1. It then checks the results. Bank 1 must be flagged with the right count, bank 0 must be clear, and `rd_bank` must point at bank 1. The ACK is expected through the handshake scoreboard.

// File: rtl/ppep_pkg.sv
package ppep_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  typedef enum logic [1:0] {
    M_STORE = 2'b00,
    M_NAK   = 2'b01,
    M_STALL = 2'b10
  } mode_e;

  function automatic hs_e mode_to_hs(mode_e m);
    case (m)
      M_STORE: return HS_ACK;
      M_NAK:   return HS_NAK;
      default: return HS_STALL;
    endcase
  endfunction
endpackage

// File: rtl/ppep_rx_ctrl.sv
module ppep_rx_ctrl
  import ppep_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DW      = 8,
  localparam int AW     = $clog2(MAX_PKT),
  localparam int CW     = $clog2(MAX_PKT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_out,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_last,
  input  logic          rx_crc_ok,
  output logic          rx_ready,
  input  logic          force_stall,
  input  logic          wr_ptr,
  input  logic [1:0]    bank_full,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done,
  output logic          done_bank,
  output logic [CW-1:0] done_cnt,
  output logic          hs_valid,
  output logic [1:0]    hs_code
);
  logic          in_pkt;
  mode_e         mode;
  logic          tgt;
  logic [CW-1:0] cnt;
  logic          beat, over_now, ok_end;

  // Beats are taken only inside the packet window.
  assign rx_ready = in_pkt;
  assign beat     = rx_valid && in_pkt;
  // Once MAX_PKT bytes have arrived, any further byte is an overrun.
  assign over_now = (cnt >= CW'(MAX_PKT));
  assign ok_end   = beat && rx_last && rx_crc_ok && !over_now;

  assign wr_en     = beat && (mode == M_STORE) && !over_now;
  assign wr_bank   = tgt;
  assign wr_addr   = cnt[AW-1:0];
  assign wr_data   = rx_data;
  assign done      = ok_end && (mode == M_STORE);
  assign done_bank = tgt;
  assign done_cnt  = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      mode     <= M_STORE;
      tgt      <= 1'b0;
      cnt      <= '0;
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else begin
      hs_valid <= 1'b0;
      if (tok_out) begin
        // The response is settled when the token arrives.
        in_pkt <= 1'b1;
        cnt    <= '0;
        tgt    <= wr_ptr;
        if (force_stall)         mode <= M_STALL;
        else if (bank_full[wr_ptr]) mode <= M_NAK;
        else                     mode <= M_STORE;
      end else if (beat) begin
        if (!over_now) cnt <= cnt + CW'(1);
        if (rx_last) begin
          in_pkt <= 1'b0;
          if (ok_end) begin
            hs_valid <= 1'b1;
            hs_code  <= mode_to_hs(mode);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ppep_flags.sv
module ppep_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_ev,
  input  logic       set_bank,
  input  logic [1:0] clr,
  output logic [1:0] full,
  output logic       wr_ptr,
  output logic       rd_ptr
);
  logic [1:0] clr_eff, set_vec;

  // A clear pulse counts only for a bank that is actually full.
  assign clr_eff = clr & full;
  assign set_vec = set_ev ? (2'b01 << set_bank) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 2'b00;
      wr_ptr <= 1'b0;
      rd_ptr <= 1'b0;
    end else begin
      full <= (full & ~clr_eff) | set_vec;
      if (set_ev)           wr_ptr <= ~wr_ptr;
      if (clr_eff[rd_ptr])  rd_ptr <= ~rd_ptr;
    end
  end
endmodule

// File: rtl/ppep_bank_store.sv
module ppep_bank_store #(
  parameter int MAX_PKT = 64,
  parameter int DW      = 8,
  localparam int AW     = $clog2(MAX_PKT),
  localparam int CW     = $clog2(MAX_PKT + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_bank,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               done,
  input  logic               done_bank,
  input  logic [CW-1:0]      done_cnt,
  input  logic               rd_sel,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [1:0][CW-1:0] cnt_o
);
  logic [1:0][DW-1:0] rd_word;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [MAX_PKT];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                            cnt_o[b] <= '0;
      else if (done && (done_bank == 1'(b))) cnt_o[b] <= done_cnt;
    end

    assign rd_word[b] = mem[rd_addr];
  end

  assign rd_data = rd_word[rd_sel];
endmodule

// File: rtl/ppep_out_endpoint.sv
module ppep_out_endpoint #(
  parameter int MAX_PKT = 64,
  parameter int DW      = 8,
  localparam int AW     = $clog2(MAX_PKT),
  localparam int CW     = $clog2(MAX_PKT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_out,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_last,
  input  logic          rx_crc_ok,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  input  logic          force_stall,
  output logic [1:0]    bank_full,
  input  logic [1:0]    bank_clr,
  output logic [CW-1:0] bank0_cnt,
  output logic [CW-1:0] bank1_cnt,
  output logic          rd_bank,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  logic               wr_ptr, wr_en, wr_bank, done, done_bank;
  logic [AW-1:0]      wr_addr;
  logic [DW-1:0]      wr_data;
  logic [CW-1:0]      done_cnt;
  logic [1:0][CW-1:0] cnts;

  ppep_rx_ctrl #(.MAX_PKT(MAX_PKT), .DW(DW)) u_rx (
    .clk, .rst_n, .tok_out, .rx_valid, .rx_data, .rx_last, .rx_crc_ok,
    .rx_ready, .force_stall, .wr_ptr, .bank_full,
    .wr_en, .wr_bank, .wr_addr, .wr_data,
    .done, .done_bank, .done_cnt, .hs_valid, .hs_code
  );

  ppep_flags u_flags (
    .clk, .rst_n, .set_ev(done), .set_bank(done_bank), .clr(bank_clr),
    .full(bank_full), .wr_ptr, .rd_ptr(rd_bank)
  );

  ppep_bank_store #(.MAX_PKT(MAX_PKT), .DW(DW)) u_store (
    .clk, .rst_n, .wr_en, .wr_bank, .wr_addr, .wr_data,
    .done, .done_bank, .done_cnt, .rd_sel, .rd_addr, .rd_data,
    .cnt_o(cnts)
  );

  assign bank0_cnt = cnts[0];
  assign bank1_cnt = cnts[1];
  assign irq       = |bank_full;
endmodule

// File: rtl/ppep_out_endpoint_chk.sv
module ppep_out_endpoint_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_out,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_last,
  input logic       hs_valid,
  input logic [1:0] hs_code,
  input logic [1:0] bank_full,
  input logic [1:0] bank_clr,
  input logic       rd_bank
);
  // R2: a flag rises only together with an ACK.
  assert_flag0_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bank_full[0]) |-> (hs_valid && hs_code == 2'b01));
  assert_flag1_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bank_full[1]) |-> (hs_valid && hs_code == 2'b01));

  // R4 and R6: a NAK or a STALL sets no flag.
  assert_refuse_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code != 2'b01) |-> (!$rose(bank_full[0]) && !$rose(bank_full[1])));

  // R5: clearing the pointed, full bank moves the read pointer.
  assert_rd_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_clr[rd_bank] && bank_full[rd_bank]) |=> (rd_bank != $past(rd_bank)));

  // R7: a handshake only follows an accepted last beat.
  assert_hs_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(rx_valid && rx_ready && rx_last));

  // R9: the window closes only on a last beat, and a token reopens it.
  assert_window_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rx_valid && rx_last && !tok_out));
  assert_window_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |=> rx_ready);
endmodule

bind ppep_out_endpoint ppep_out_endpoint_chk u_chk (
  .clk, .rst_n, .tok_out, .rx_valid, .rx_ready, .rx_last,
  .hs_valid, .hs_code, .bank_full, .bank_clr, .rd_bank
);

// File: tb/tb_ppep_out_endpoint.sv
`timescale 1ns/1ps
module tb_ppep_out_endpoint;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_out = 1'b0, rx_valid = 1'b0, rx_last = 1'b0, rx_crc_ok = 1'b0;
  logic [7:0] rx_data = '0;
  logic       force_stall = 1'b0, rd_sel = 1'b0;
  logic [1:0] bank_clr = '0;
  logic [5:0] rd_addr = '0;
  logic       rx_ready, hs_valid, rd_bank, irq;
  logic [1:0] hs_code, bank_full;
  logic [6:0] bank0_cnt, bank1_cnt;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  int         exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  ppep_out_endpoint dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compare every handshake against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && hs_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7/R8: actual unexpected handshake %0h expected none", hs_code);
      end else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (hs_code !== 2'(e)) begin
          errors++;
          $display("FAIL %s: actual handshake %0h expected %0h", t, hs_code, e);
        end
      end
    end
  end

  // Driver: token then len bytes; pushes the expected handshake.
  task automatic send(int len, logic [7:0] seed, logic crc, int exp_hs,
                      string tag, logic [1:0] clr_last = 2'b00);
    if (exp_hs != 0) begin
      exp_q.push_back(exp_hs);
      tag_q.push_back(tag);
    end
    @(posedge clk); #1 tok_out = 1'b1;
    @(posedge clk); #1 tok_out = 1'b0;
    check("R9 ready after token", rx_ready, 1'b1);
    for (int i = 0; i < len; i++) begin
      rx_valid  = 1'b1;
      rx_data   = seed + 8'(i);
      rx_last   = (i == len - 1);
      rx_crc_ok = (i == len - 1) ? crc : 1'b0;
      bank_clr  = (i == len - 1) ? clr_last : 2'b00;
      @(posedge clk); #1;
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_crc_ok = 1'b0; bank_clr = 2'b00;
  endtask

  task automatic clear(logic [1:0] m);
    @(posedge clk); #1 bank_clr = m;
    @(posedge clk); #1 bank_clr = 2'b00;
  endtask

  task automatic rd(logic sel, int addr, logic [7:0] exp, string req);
    rd_sel = sel; rd_addr = 6'(addr); #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset ready", rx_ready, 0);
    check("R3 reset flags", bank_full, 0);
    check("R3 reset irq", irq, 0);
    check("R5 reset rd_bank", rd_bank, 0);

    // R1/R2: first packet to bank 0, second to bank 1 (max size).
    send(10, 8'h10, 1, 1, "R2 ack A");
    check("R1 A in bank0", bank_full, 2'b01);
    check("R2 count A", bank0_cnt, 10);
    check("R3 irq one flag", irq, 1);
    send(64, 8'h40, 1, 1, "R2 ack B");
    check("R1 B in bank1", bank_full, 2'b11);
    check("R2 count 64", bank1_cnt, 64);
    rd(1, 63, 8'h7F, "R10 bank1 last byte");

    // R4: bank 0 still full -> NAK, nothing stored.
    send(5, 8'hEE, 1, 2, "R4 nak");
    check("R4 flags after nak", bank_full, 2'b11);
    check("R4 count kept", bank0_cnt, 10);
    for (int i = 0; i < 10; i++) rd(0, i, 8'h10 + 8'(i), "R10 bank0 bytes");
    check("R5 oldest is bank0", rd_bank, 0);

    // R5: clear pointed bank, then a clear of an empty bank is ignored.
    clear(2'b01);
    check("R5 clear bank0", bank_full, 2'b10);
    check("R5 rd moves", rd_bank, 1);
    clear(2'b01);
    check("R5 empty clear flags", bank_full, 2'b10);
    check("R5 empty clear rd", rd_bank, 1);

    // R1: third packet back to bank 0 once released.
    send(3, 8'h80, 1, 1, "R1 ack D");
    check("R1 D in bank0", bank_full, 2'b11);
    check("R2 count D", bank0_cnt, 3);
    rd(0, 2, 8'h82, "R10 bank0 D byte2");
    clear(2'b10);
    check("R5 rd back to 0", rd_bank, 0);

    // Same-cycle completion into bank 1 and clear of bank 0.
    send(6, 8'hA0, 1, 1, "R2 ack E", 2'b01);
    check("R5 concurrent flags", bank_full, 2'b10);
    check("R5 concurrent rd", rd_bank, 1);
    check("R2 concurrent count", bank1_cnt, 6);

    // R6: forced stall.
    force_stall = 1'b1;
    send(4, 8'h55, 1, 3, "R6 stall");
    force_stall = 1'b0;
    check("R6 flags after stall", bank_full, 2'b10);
    check("R6 count after stall", bank0_cnt, 3);

    // R7: bad CRC, then the pointer must still be at bank 0.
    send(4, 8'h66, 0, 0, "R7");
    check("R7 flags after bad crc", bank_full, 2'b10);
    send(7, 8'hC0, 1, 1, "R7 ack F");
    check("R7 F in bank0", bank_full, 2'b11);
    check("R7 count F", bank0_cnt, 7);
    clear(2'b10);
    clear(2'b01);
    check("R3 irq idle", irq, 0);
    check("R5 rd after two clears", rd_bank, 1);

    // R8: oversize, then next packet goes to bank 1.
    send(65, 8'h00, 1, 0, "R8");
    check("R8 flags after oversize", bank_full, 2'b00);
    send(2, 8'hE0, 1, 1, "R8 ack G");
    check("R8 G in bank1", bank_full, 2'b10);
    check("R8 count G", bank1_cnt, 2);

    // R9: beat outside window is ignored.
    @(posedge clk); #1 rx_valid = 1'b1; rx_last = 1'b1; rx_crc_ok = 1'b1;
    @(posedge clk); #1 rx_valid = 1'b0; rx_last = 1'b0; rx_crc_ok = 1'b0;
    @(negedge clk);
    check("R9 stray beat flags", bank_full, 2'b10);
    check("R9 stray beat count", bank1_cnt, 2);

    repeat (4) @(posedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule